// File: doc/BRIEF.md
# Sector-Addressed Accumulator Instruction Sequencer

This block fetches 13-bit instruction syllables from a synchronous memory and executes them on a 26-bit accumulator. Each syllable carries a 4-bit operation code in its upper bits and a 9-bit operand. Memory is split into sectors of 256 words. The eighth operand bit (bit 8) picks one of two places to look. It either uses the data sector held in an internal register, or it uses a shared residual sector that is fixed at sector 0.

A state machine with three states steps through each instruction. `ST_FETCH` reads the word at the program counter and always moves to `ST_DECODE`. In `ST_DECODE` the fetched syllable is classified. Instructions that need a memory operand issue the operand read and take the transition to `ST_EXEC`. All other instructions complete in `ST_DECODE` and take the transition back to `ST_FETCH`. `ST_EXEC` writes the accumulator result and always returns to `ST_FETCH`.

Program counter, accumulator and data sector are internal registers. They are brought out read-only for observation, together with a `retire` strobe that marks the last cycle of each instruction. Multiply, divide, I/O, indirect hop and execute-modify are not carried out. They raise `unimpl` and otherwise behave as a no-op.

Top module: `sect_acc_core`

## Requirements
- R1: While `rst_n` is low and after it is released, program counter, accumulator and data sector read zero, and no write is issued.
- R2: Each instruction begins with a read of the program counter address. Instructions with a memory operand (codes 0010, 1101, 0111, 0110, 1001, 1111) assert `retire` three cycles after that fetch cycle, counting the fetch cycle as the first. All other instructions assert it in the second cycle. `retire` is never high two cycles in a row.
- R3: The effective address is {0, operand[7:0]} when operand bit 8 is 1 (residual sector). It is {data sector, operand[7:0]} when operand bit 8 is 0.
- R4: Arithmetic, all modulo 2^26: code 0111 sets acc = acc + M, code 0010 sets acc = acc − M, and code 1101 sets acc = M − acc.
- R5: Code 0110 sets acc = acc AND M, code 1001 sets acc = acc XOR M, and code 1111 sets acc = M.
- R6: Code 1011 writes the accumulator to the effective address for one cycle, during the retire cycle. The accumulator is left unchanged.
- R7: Code 1000 always jumps. Code 0100 jumps when acc ≠ 0. Code 1100 jumps when acc bit 25 is 1. A jump target keeps the program counter's sector bits and takes operand[7:0] as the word. Any other instruction, including a branch that is not taken, sets pc = pc + 1, wrapping over the whole address space.
- R8: Code 1110 is sub-decoded by operand[1:0]. When operand[0] = 0 it changes the data sector, loading it from operand[5:2]. The value 01 selects a shift. The value 11 selects execute-modify.
- R9: For the shift, the amount n is operand[3:2], where the value 3 counts as 2. Operand[4] = 1 shifts left and fills with zeros. Operand[4] = 0 shifts right arithmetically. When n = 0 the accumulator is cleared.
- R10: Codes 0000, 0001, 0011, 0101 and 1010, and execute-modify, pulse `unimpl` in their retire cycle. They leave the accumulator and the data sector unchanged and advance pc by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory address for fetch, operand read or store |
| mem_rd_en | output | 1 | Read request; data is returned on the next cycle |
| mem_rdata | input | 26 | Read data; the syllable is taken from the low 13 bits |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 26 | Write data |
| retire | output | 1 | Last cycle of an instruction |
| unimpl | output | 1 | Unimplemented instruction in its retire cycle |
| pc_o | output | 12 | Program counter |
| acc_o | output | 26 | Accumulator |
| dsec_o | output | 4 | Data sector register |

## Verification
The assertions assume the memory returns read data exactly one cycle after `mem_rd_en` and never holds back a request. The bench's memory model keeps to this on every access. The properties also take for granted that `rst_n` is synchronous with the clock, and the bench only changes it at falling edges. Random programs fill the whole address space, including code that its own stores overwrite. About one data word in eight is forced to zero, so that both the taken and the untaken outcomes of the zero and sign tests actually occur.

// File: rtl/sac_pkg.sv
package sac_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_HOP = 4'd0,  OPC_MPY = 4'd1,  OPC_SUB = 4'd2,  OPC_DIV = 4'd3,
        OPC_TNZ = 4'd4,  OPC_MPH = 4'd5,  OPC_AND = 4'd6,  OPC_ADD = 4'd7,
        OPC_TRA = 4'd8,  OPC_XOR = 4'd9,  OPC_PIO = 4'd10, OPC_STO = 4'd11,
        OPC_TMI = 4'd12, OPC_RSU = 4'd13, OPC_GRP = 4'd14, OPC_CLA = 4'd15
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2
    } state_e;

    typedef enum logic [2:0] {
        ALU_NONE, ALU_ADD, ALU_SUB, ALU_RSU, ALU_AND, ALU_XOR, ALU_LOAD
    } alu_e;

    typedef enum logic [1:0] {
        BR_NONE, BR_ALWAYS, BR_NZ, BR_NEG
    } br_e;

    typedef struct packed {
        alu_e alu;
        br_e  br;
        logic mem_rd;
        logic store;
        logic shift;
        logic set_sect;
        logic unimpl;
    } dec_t;

endpackage

// File: rtl/sac_decode.sv
module sac_decode
    import sac_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    input  logic [1:0]       sub_i,
    output dec_t             dec_o
);

    always_comb begin
        dec_o = '0;
        unique case (opcode_e'(opc_i))
            OPC_ADD: begin dec_o.alu = ALU_ADD;  dec_o.mem_rd = 1'b1; end
            OPC_SUB: begin dec_o.alu = ALU_SUB;  dec_o.mem_rd = 1'b1; end
            OPC_RSU: begin dec_o.alu = ALU_RSU;  dec_o.mem_rd = 1'b1; end
            OPC_AND: begin dec_o.alu = ALU_AND;  dec_o.mem_rd = 1'b1; end
            OPC_XOR: begin dec_o.alu = ALU_XOR;  dec_o.mem_rd = 1'b1; end
            OPC_CLA: begin dec_o.alu = ALU_LOAD; dec_o.mem_rd = 1'b1; end
            OPC_STO: dec_o.store = 1'b1;
            OPC_TRA: dec_o.br = BR_ALWAYS;
            OPC_TNZ: dec_o.br = BR_NZ;
            OPC_TMI: dec_o.br = BR_NEG;
            OPC_GRP: begin
                if (!sub_i[0])      dec_o.set_sect = 1'b1;
                else if (!sub_i[1]) dec_o.shift    = 1'b1;
                else                dec_o.unimpl   = 1'b1;
            end
            OPC_HOP, OPC_MPY, OPC_DIV, OPC_MPH, OPC_PIO: dec_o.unimpl = 1'b1;
        endcase
    end

endmodule

// File: rtl/sac_alu.sv
module sac_alu
    import sac_pkg::*;
#(
    parameter int DATA_W = 26
) (
    input  alu_e              op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] mem_i,
    output logic [DATA_W-1:0] res_o
);

    always_comb begin
        case (op_i)
            ALU_ADD:  res_o = acc_i + mem_i;
            ALU_SUB:  res_o = acc_i - mem_i;
            ALU_RSU:  res_o = mem_i - acc_i;
            ALU_AND:  res_o = acc_i & mem_i;
            ALU_XOR:  res_o = acc_i ^ mem_i;
            ALU_LOAD: res_o = mem_i;
            default:  res_o = acc_i;
        endcase
    end

endmodule

// File: rtl/sac_shift.sv
module sac_shift #(
    parameter int DATA_W = 26
) (
    input  logic [DATA_W-1:0] acc_i,
    input  logic              left_i,
    input  logic [1:0]        amt_i,
    output logic [DATA_W-1:0] res_o
);

    logic [1:0] amt_eff;

    always_comb begin
        amt_eff = (amt_i == 2'd3) ? 2'd2 : amt_i;
        if (amt_i == 2'd0)
            res_o = '0;
        else if (left_i)
            res_o = acc_i << amt_eff;
        else
            res_o = DATA_W'($signed(acc_i) >>> amt_eff);
    end

endmodule

// File: rtl/sect_acc_core.sv
module sect_acc_core
    import sac_pkg::*;
#(
    parameter int SECT_W = 4,
    parameter int WORD_W = 8,
    parameter int DATA_W = 26
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic [SECT_W+WORD_W-1:0] mem_addr,
    output logic                     mem_rd_en,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic                     mem_wr_en,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic                     retire,
    output logic                     unimpl,
    output logic [SECT_W+WORD_W-1:0] pc_o,
    output logic [DATA_W-1:0]        acc_o,
    output logic [SECT_W-1:0]        dsec_o
);

    localparam int ADDR_W = SECT_W + WORD_W;
    localparam int OPD_W  = WORD_W + 1;
    localparam int SYL_W  = OPC_W + OPD_W;

    state_e              state_q, state_d;
    logic [SYL_W-1:0]    ir_q;
    logic [ADDR_W-1:0]   pc_q;
    logic [DATA_W-1:0]   acc_q;
    logic [SECT_W-1:0]   dsec_q;

    logic [SYL_W-1:0]    instr;
    logic [OPD_W-1:0]    opd;
    dec_t                dec;
    logic [ADDR_W-1:0]   eff_addr;
    logic [ADDR_W-1:0]   pc_inc;
    logic [ADDR_W-1:0]   pc_next;
    logic                taken;
    logic [DATA_W-1:0]   alu_res;
    logic [DATA_W-1:0]   shf_res;

    // The syllable comes straight from memory while decoding, from the copy afterwards.
    assign instr = (state_q == ST_DECODE) ? mem_rdata[SYL_W-1:0] : ir_q;
    assign opd   = instr[OPD_W-1:0];

    sac_decode u_dec (
        .opc_i (instr[SYL_W-1:OPD_W]),
        .sub_i (opd[1:0]),
        .dec_o (dec)
    );

    sac_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i  (dec.alu),
        .acc_i (acc_q),
        .mem_i (mem_rdata),
        .res_o (alu_res)
    );

    sac_shift #(.DATA_W(DATA_W)) u_shf (
        .acc_i  (acc_q),
        .left_i (opd[4]),
        .amt_i  (opd[3:2]),
        .res_o  (shf_res)
    );

    // Residual sector is sector zero; the top operand bit selects it.
    assign eff_addr = opd[WORD_W] ? {{SECT_W{1'b0}}, opd[WORD_W-1:0]}
                                  : {dsec_q, opd[WORD_W-1:0]};
    assign pc_inc   = pc_q + ADDR_W'(1);

    always_comb begin
        case (dec.br)
            BR_ALWAYS: taken = 1'b1;
            BR_NZ:     taken = (acc_q != '0);
            BR_NEG:    taken = acc_q[DATA_W-1];
            default:   taken = 1'b0;
        endcase
        pc_next = taken ? {pc_q[ADDR_W-1:WORD_W], opd[WORD_W-1:0]} : pc_inc;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        mem_addr  = pc_q;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        retire    = 1'b0;
        unimpl    = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                mem_rd_en = 1'b1;
                state_d   = ST_DECODE;
            end
            ST_DECODE: begin
                mem_addr  = eff_addr;
                mem_rd_en = dec.mem_rd;
                mem_wr_en = dec.store;
                unimpl    = dec.unimpl;
                retire    = !dec.mem_rd;
                state_d   = dec.mem_rd ? ST_EXEC : ST_FETCH;
            end
            ST_EXEC: begin
                mem_addr = eff_addr;
                retire   = 1'b1;
                state_d  = ST_FETCH;
            end
            default: state_d = ST_FETCH;
        endcase
    end

    // Architectural registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q   <= '0;
            pc_q   <= '0;
            acc_q  <= '0;
            dsec_q <= '0;
        end else begin
            case (state_q)
                ST_DECODE: begin
                    ir_q <= instr;
                    if (!dec.mem_rd) pc_q <= pc_next;
                    if (dec.shift) acc_q <= shf_res;
                    if (dec.set_sect) dsec_q <= opd[2 +: SECT_W];
                end
                ST_EXEC: begin
                    acc_q <= alu_res;
                    pc_q  <= pc_inc;
                end
                default: ;
            endcase
        end
    end

    assign mem_wdata = acc_q;
    assign pc_o      = pc_q;
    assign acc_o     = acc_q;
    assign dsec_o    = dsec_q;

endmodule

// File: rtl/sac_chk.sv
module sac_chk #(
    parameter int SECT_W = 4,
    parameter int WORD_W = 8,
    parameter int DATA_W = 26
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [SECT_W+WORD_W-1:0] mem_addr,
    input logic                     mem_rd_en,
    input logic                     mem_wr_en,
    input logic                     retire,
    input logic                     unimpl,
    input logic [SECT_W+WORD_W-1:0] pc_o,
    input logic [DATA_W-1:0]        acc_o,
    input logic [SECT_W-1:0]        dsec_o
);

    AST_RETIRE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire); // R2
    AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (mem_rd_en && mem_addr == pc_o)); // R2
    AST_ACC_ONLY_AT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !retire |=> $stable(acc_o)); // R4
    AST_SECT_ONLY_AT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !retire |=> $stable(dsec_o)); // R8
    AST_WRITE_AT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (retire && !mem_rd_en)); // R6
    AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> $stable(acc_o)); // R6
    AST_UNIMPL_AT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        unimpl |-> (retire && !mem_wr_en)); // R10
    AST_UNIMPL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        unimpl |=> ($stable(acc_o) && $stable(dsec_o))); // R10

endmodule

bind sect_acc_core sac_chk #(.SECT_W(SECT_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .retire    (retire),
    .unimpl    (unimpl),
    .pc_o      (pc_o),
    .acc_o     (acc_o),
    .dsec_o    (dsec_o)
);

// File: tb/sect_acc_core_tb_top.sv
module sect_acc_core_tb_top;

    localparam int AW = 12;
    localparam int DW = 26;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd_en;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_wr_en;
    logic [DW-1:0] mem_wdata;
    logic          retire, unimpl;
    logic [AW-1:0] pc_o;
    logic [DW-1:0] acc_o;
    logic [SW-1:0] dsec_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [DW-1:0] mem     [1<<AW];
    logic [DW-1:0] ref_mem [1<<AW];
    logic [AW-1:0] r_pc;
    logic [DW-1:0] r_acc;
    logic [SW-1:0] r_dsec;

    always #2.5 clk = ~clk;

    sect_acc_core dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
        .retire(retire), .unimpl(unimpl), .pc_o(pc_o), .acc_o(acc_o), .dsec_o(dsec_o)
    );

    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ins(input logic [3:0] opc, input logic [8:0] opd);
        return DW'({opc, opd});
    endfunction

    function automatic string tag_of(input logic [3:0] opc, input logic [8:0] opd);
        case (opc)
            4'd7, 4'd2, 4'd13: return "R4 arith";
            4'd6, 4'd9, 4'd15: return "R5 logic/load";
            4'd11:             return "R6 store";
            4'd8, 4'd4, 4'd12: return "R7 transfer";
            4'd14: begin
                if (!opd[0])        return "R8 sector";
                else if (!opd[1])   return "R9 shift";
                else                return "R10 exec-modify";
            end
            default:           return "R10 unimpl";
        endcase
    endfunction

    function automatic logic [DW-1:0] shift_ref(input logic [DW-1:0] a, input logic [8:0] opd);
        int n;
        n = (opd[3:2] == 2'd3) ? 2 : int'(opd[3:2]);
        if (n == 0) return '0;
        if (opd[4]) return a << n;
        return DW'($signed(a) >>> n);
    endfunction

    // Reference step; returns expected store, unimplemented flag and cycle count.
    task automatic ref_step(output bit e_wr, output logic [AW-1:0] e_wa, output logic [DW-1:0] e_wd,
                            output bit e_un, output int e_len, output string tag);
        logic [12:0]   s;
        logic [3:0]    opc;
        logic [8:0]    opd;
        logic [AW-1:0] ea, npc;
        logic [DW-1:0] m;
        s   = ref_mem[r_pc][12:0];
        opc = s[12:9];
        opd = s[8:0];
        ea  = opd[8] ? {4'h0, opd[7:0]} : {r_dsec, opd[7:0]};
        m   = ref_mem[ea];
        npc = r_pc + 1'b1;
        e_wr = 0; e_wa = ea; e_wd = r_acc; e_un = 0; e_len = 2;
        tag = tag_of(opc, opd);
        case (opc)
            4'd7:  begin r_acc = r_acc + m; e_len = 3; end
            4'd2:  begin r_acc = r_acc - m; e_len = 3; end
            4'd13: begin r_acc = m - r_acc; e_len = 3; end
            4'd6:  begin r_acc = r_acc & m; e_len = 3; end
            4'd9:  begin r_acc = r_acc ^ m; e_len = 3; end
            4'd15: begin r_acc = m;         e_len = 3; end
            4'd11: begin e_wr = 1; ref_mem[ea] = r_acc; end
            4'd8:  npc = {r_pc[11:8], opd[7:0]};
            4'd4:  if (r_acc != 0) npc = {r_pc[11:8], opd[7:0]};
            4'd12: if (r_acc[DW-1]) npc = {r_pc[11:8], opd[7:0]};
            4'd14: begin
                if (!opd[0])      r_dsec = opd[5:2];
                else if (!opd[1]) r_acc = shift_ref(r_acc, opd);
                else              e_un = 1;
            end
            default: e_un = 1;
        endcase
        r_pc = npc;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(pc_o == 0 && acc_o == 0 && dsec_o == 0 && !mem_wr_en, "R1 reset state",
            {pc_o, 20'(acc_o != 0)}, 32'd0);
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = mem[i];
        r_pc = '0; r_acc = '0; r_dsec = '0;
        rst_n = 1'b1;
    endtask

    task automatic run(input int n_ret);
        int nret = 0, last = 0, cyc = 0, e_len = 2;
        bit pending = 0, first = 1, e_wr, e_un;
        logic [AW-1:0] e_wa;
        logic [DW-1:0] e_wd;
        string tag;
        while ((nret < n_ret || pending) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (pending) begin
                chk(acc_o == r_acc, {tag, " acc"}, 32'(acc_o), 32'(r_acc));
                chk(pc_o == r_pc, {tag, " pc (R7)"}, 32'(pc_o), 32'(r_pc));
                chk(dsec_o == r_dsec, {tag, " sector (R8)"}, 32'(dsec_o), 32'(r_dsec));
                pending = 0;
            end
            if (retire && nret < n_ret) begin
                // R3: effective address is checked through the operand that reaches acc and the store address
                ref_step(e_wr, e_wa, e_wd, e_un, e_len, tag);
                if (!first) chk(cyc - last == e_len, {tag, " R2 retire spacing"}, 32'(cyc - last), 32'(e_len));
                first = 0;
                last = cyc;
                chk(mem_wr_en == e_wr, {tag, " R6 write strobe"}, 32'(mem_wr_en), 32'(e_wr));
                if (e_wr) begin
                    chk(mem_addr == e_wa, {tag, " R3 store address"}, 32'(mem_addr), 32'(e_wa));
                    chk(mem_wdata == e_wd, {tag, " R6 store data"}, 32'(mem_wdata), 32'(e_wd));
                end
                chk(unimpl == e_un, {tag, " R10 flag"}, 32'(unimpl), 32'(e_un));
                pending = 1;
                nret++;
            end
        end
        if (cyc >= 20000) chk(0, "R2 run stalled", 32'(nret), 32'(n_ret));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(0, "R2 watchdog", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        // Directed program
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
        mem[0]  = ins(4'd14, 9'h00C);  // change data sector to 3
        mem[1]  = ins(4'd15, 9'h005);  // load from sector 3 word 5
        mem[2]  = ins(4'd7,  9'h140);  // add residual word 0x40
        mem[3]  = ins(4'd14, 9'h019);  // shift left by 2
        mem[4]  = ins(4'd11, 9'h141);  // store to residual 0x41
        mem[5]  = ins(4'd14, 9'h001);  // shift amount 0: clear
        mem[6]  = ins(4'd4,  9'h00A);  // not taken
        mem[7]  = ins(4'd13, 9'h140);  // 7 - 0
        mem[8]  = ins(4'd2,  9'h142);  // 7 - 10
        mem[9]  = ins(4'd12, 9'h00C);  // taken to 12
        mem[12] = ins(4'd1,  9'h000);  // multiply: unimplemented
        mem[13] = ins(4'd8,  9'h00D);  // loop on itself
        mem[12'h305] = 26'd123;
        mem[12'h040] = 26'd7;
        mem[12'h042] = 26'd10;
        do_reset();
        run(14);
        chk(mem[12'h041] == 26'd520, "R3 R6 directed stored value", 32'(mem[12'h041]), 32'd520);
        chk(acc_o == 26'h3FFFFFD, "R4 R9 directed acc", 32'(acc_o), 32'h3FFFFFD);
        chk(pc_o == 12'd13, "R7 directed pc", 32'(pc_o), 32'd13);
        chk(dsec_o == 4'd3, "R8 directed sector", 32'(dsec_o), 32'd3);
        // Random programs
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < (1 << AW); i++) begin
                logic [DW-1:0] w;
                w = DW'({$urandom, $urandom});
                if ($urandom_range(7) == 0) w = {w[DW-1:13], 13'h0} & 26'h0;
                if ($urandom_range(9) == 0) w = {w[DW-1:13], ins(4'd14, 9'(w[8:0]))[12:0]};
                mem[i] = w;
            end
            do_reset();
            run(600);
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule